// File: doc/BRIEF.md
# Hibernation Wake and Supply-Enable Controller

This block runs on the always-on clock of a chip that hibernates by switching off its own main supply. It watches four wake pins, an active-low reset-button pin and a timer-expiry strobe. When any enabled wake condition occurs, it raises the supply-enable output. Firmware can still set a general-purpose output pin while the chip is running, and that pin keeps its level through hibernation.

Each wake pin has its own trigger type and polarity: level or edge, and active-high/rising or active-low/falling. All pin inputs go through a two-stage synchroniser. A filter that needs three agreeing samples can be switched in to reject glitches. The supply-enable output has two modes. In level mode it is a steady enable that the firmware drops with a hibernate command. In pulse mode it gives one fixed-width pulse to an external power manager, and it can then be driven as open-drain.

The control path is a plain single-cycle register port: a write strobe, a 2-bit address and 8-bit write data. Read data is combinational from the address. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `hwk_wake_ctrl`

## Requirements
- R1: After power-on reset the supply enable is high and driven (push-pull), the general output and the configuration-error flag are low, and the four registers read 0x00 (address 0), 0x55 (address 1), 0x00 (address 2) and 0x00 (address 3).
- R2: Address 0 bit (i+4) selects the trigger type of pin i (0 = level, 1 = edge). Address 1 bit (2·i) selects its polarity (1 = active-high/rising, 0 = active-low/falling). A level-triggered pin gives a wake in every cycle that its conditioned value equals its polarity.
- R3: An edge-triggered pin gives a wake only on a transition of its conditioned value in the selected direction. A transition in the other direction has no effect.
- R4: Each pin passes through a two-flop synchroniser. With glitch protection on (address 3 bit 0), the conditioned value changes only after three consecutive agreeing synchronised samples, so a pulse of one or two cycles causes no wake.
- R5: In level mode (address 2 bit 0 = 0), writing 1 to address 2 bit 6 drops the supply enable at that clock edge. Any wake raises it at the next edge. If a wake and the hibernate command fall in the same cycle, the wake wins.
- R6: In pulse mode (address 2 bit 0 = 1), the supply enable idles low. A wake starts exactly one high pulse of 4 cycles. Wakes during a pulse do not extend or restart it, and the hibernate command has no effect.
- R7: Open-drain (address 2 bit 1) in pulse mode drives the pad only while the enable is low. Open-drain set in level mode raises the configuration-error output, and the pad stays push-pull.
- R8: With address 2 bit 2 set, a falling edge of the conditioned reset-button input is a wake source and sets status bit 3 of address 2.
- R9: The lock bit (address 3 bit 1), once written to 1, ignores further writes to itself and to address 2 bit 2 until power-on reset.
- R10: A timer-expiry strobe is a wake source in either mode and sets status bit 4 of address 2.
- R11: Pin wake status sits in address 0 bits 3:0. All status bits are cleared by writing 1, and a new event in the same cycle as the clear leaves the bit set.
- R12: Address 2 bit 5 drives the general output. It changes only on a write to address 2 and is untouched by hibernate commands and wakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ao | input | 1 | Always-on clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| wake_pin_i | input | 4 | Raw wake pins |
| rstbtn_n_i | input | 1 | Raw reset-button pin, active low |
| tmr_evt_i | input | 1 | Timer-expiry strobe, always-on domain |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| pwr_en_o | output | 1 | Supply-enable value |
| pwr_en_oe_o | output | 1 | Supply-enable pad drive enable |
| gpo_o | output | 1 | Retained general-purpose output |
| cfg_err_o | output | 1 | Open-drain requested in level mode |

## Verification
Two pairs of events can fall in the same cycle. The first is a hibernate command together with a wake, from a level-held pin or the timer strobe, which the requirements resolve in favour of the wake. The second is a status clear together with a new event on the same bit. The bench provokes both by raising the timer strobe or holding a pin active in the exact cycle of the register write. A behavioural reference model, compared on every clock, then checks that the enable stays high and the status bit stays set. The same model also checks the pulse width, the non-retriggering and the filter's rejection of one- and two-cycle glitches.

// File: rtl/hwk_pkg.sv
`timescale 1ns/1ps
package hwk_pkg;
  localparam int NPIN  = 4;
  localparam int REG_W = 8;
  localparam int AW    = 2;

  localparam logic [AW-1:0] A_TRIG  = 2'd0;
  localparam logic [AW-1:0] A_POL   = 2'd1;
  localparam logic [AW-1:0] A_MCTL  = 2'd2;
  localparam logic [AW-1:0] A_MCTL2 = 2'd3;

  localparam int MC_PULSE   = 0;
  localparam int MC_OD      = 1;
  localparam int MC_BTN_EN  = 2;
  localparam int MC_BTN_EVT = 3;
  localparam int MC_TMR_EVT = 4;
  localparam int MC_GPO     = 5;
  localparam int MC_HIB     = 6;

  localparam int M2_GLITCH  = 0;
  localparam int M2_LOCK    = 1;

  localparam logic [NPIN-1:0] POL_RST = '1;
endpackage

// File: rtl/hwk_sync_filter.sv
`timescale 1ns/1ps
module hwk_sync_filter #(
  parameter int   SYNC_DEPTH = 2,
  parameter int   FILT_DEPTH = 3,
  parameter logic RST_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic glitch_en,
  output logic filt
);
  localparam int HW = FILT_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sync_q;
  logic [HW-1:0]         hist_q;
  logic                  held_q;
  logic                  smp;
  logic [HW:0]           window;
  logic                  agree;

  assign smp    = sync_q[SYNC_DEPTH-1];
  assign window = {hist_q, smp};
  assign agree  = (&window) | ~(|window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_DEPTH{RST_VAL}};
      hist_q <= {HW{RST_VAL}};
      held_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_DEPTH-2:0], din};
      for (int k = HW - 1; k > 0; k--) hist_q[k] <= hist_q[k-1];
      hist_q[0] <= smp;
      if (agree) held_q <= smp;
    end
  end

  assign filt = glitch_en ? held_q : smp;
endmodule

// File: rtl/hwk_pin_detect.sv
`timescale 1ns/1ps
module hwk_pin_detect #(
  parameter int   SYNC_DEPTH = 2,
  parameter int   FILT_DEPTH = 3,
  parameter logic RST_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic glitch_en,
  input  logic edge_mode,
  input  logic pol,
  output logic hit
);
  logic filt;
  logic prev_q;
  logic rise;
  logic fall;

  hwk_sync_filter #(
    .SYNC_DEPTH(SYNC_DEPTH),
    .FILT_DEPTH(FILT_DEPTH),
    .RST_VAL   (RST_VAL)
  ) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .glitch_en(glitch_en),
    .filt     (filt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= filt;
  end

  assign rise = filt & ~prev_q;
  assign fall = ~filt & prev_q;
  assign hit  = edge_mode ? (pol ? rise : fall) : (filt == pol);
endmodule

// File: rtl/hwk_regs.sv
`timescale 1ns/1ps
module hwk_regs
  import hwk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NPIN-1:0]  pin_hit,
  input  logic             btn_wake,
  input  logic             tmr_hit,
  output logic [NPIN-1:0]  trig,
  output logic [NPIN-1:0]  pol,
  output logic             pulse,
  output logic             od,
  output logic             btn_en,
  output logic             gpo,
  output logic             glitch_en,
  output logic             lock,
  output logic             hib_cmd,
  output logic [REG_W-1:0] rdata
);
  logic [NPIN-1:0] pin_evt;
  logic            btn_evt;
  logic            tmr_evt;
  logic            sel_trig, sel_pol, sel_mctl, sel_mctl2;
  logic [NPIN-1:0] pin_clr;
  logic [REG_W-1:0] pol_rd;
  logic            unused_wdata;

  assign sel_trig  = wr && (addr == A_TRIG);
  assign sel_pol   = wr && (addr == A_POL);
  assign sel_mctl  = wr && (addr == A_MCTL);
  assign sel_mctl2 = wr && (addr == A_MCTL2);
  assign pin_clr   = sel_trig ? wdata[NPIN-1:0] : '0;
  assign hib_cmd   = sel_mctl && wdata[MC_HIB];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig      <= '0;
      pol       <= POL_RST;
      pin_evt   <= '0;
      pulse     <= 1'b0;
      od        <= 1'b0;
      btn_en    <= 1'b0;
      gpo       <= 1'b0;
      btn_evt   <= 1'b0;
      tmr_evt   <= 1'b0;
      glitch_en <= 1'b0;
      lock      <= 1'b0;
    end else begin
      if (sel_trig) trig <= wdata[2*NPIN-1:NPIN];
      pin_evt <= (pin_evt & ~pin_clr) | pin_hit;
      if (sel_pol) begin
        for (int i = 0; i < NPIN; i++) pol[i] <= wdata[2*i];
      end
      if (sel_mctl) begin
        pulse <= wdata[MC_PULSE];
        od    <= wdata[MC_OD];
        gpo   <= wdata[MC_GPO];
        if (!lock) btn_en <= wdata[MC_BTN_EN];
      end
      btn_evt <= (btn_evt & ~(sel_mctl & wdata[MC_BTN_EVT])) | btn_wake;
      tmr_evt <= (tmr_evt & ~(sel_mctl & wdata[MC_TMR_EVT])) | tmr_hit;
      if (sel_mctl2) begin
        glitch_en <= wdata[M2_GLITCH];
        if (!lock) lock <= wdata[M2_LOCK];
      end
    end
  end

  always_comb begin
    pol_rd = '0;
    for (int i = 0; i < NPIN; i++) pol_rd[2*i] = pol[i];
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_TRIG: rdata = {trig, pin_evt};
      A_POL:  rdata = pol_rd;
      A_MCTL: begin
        rdata[MC_PULSE]   = pulse;
        rdata[MC_OD]      = od;
        rdata[MC_BTN_EN]  = btn_en;
        rdata[MC_BTN_EVT] = btn_evt;
        rdata[MC_TMR_EVT] = tmr_evt;
        rdata[MC_GPO]     = gpo;
      end
      default: begin
        rdata[M2_GLITCH] = glitch_en;
        rdata[M2_LOCK]   = lock;
      end
    endcase
  end
endmodule

// File: rtl/hwk_pwr_out.sv
`timescale 1ns/1ps
module hwk_pwr_out #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic hib_cmd,
  input  logic pulse,
  input  logic od,
  output logic pwr,
  output logic oe,
  output logic cfg_err
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] PLEN = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
      else if (pulse && wake)  cnt_q <= PLEN;
      if (!pulse) begin
        if (wake)         lvl_q <= 1'b1;
        else if (hib_cmd) lvl_q <= 1'b0;
      end
    end
  end

  assign pwr     = pulse ? (cnt_q != '0) : lvl_q;
  assign oe      = (od && pulse) ? ~pwr : 1'b1;
  assign cfg_err = od && !pulse;
endmodule

// File: rtl/hwk_wake_ctrl.sv
`timescale 1ns/1ps
module hwk_wake_ctrl
  import hwk_pkg::*;
#(
  parameter int PULSE_LEN  = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int FILT_DEPTH = 3
) (
  input  logic             clk_ao,
  input  logic             rst_por_n,
  input  logic [NPIN-1:0]  wake_pin_i,
  input  logic             rstbtn_n_i,
  input  logic             tmr_evt_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             pwr_en_o,
  output logic             pwr_en_oe_o,
  output logic             gpo_o,
  output logic             cfg_err_o
);
  logic [NPIN-1:0] cfg_trig, cfg_pol, pin_hit;
  logic cfg_pulse, cfg_od, cfg_btn_en, cfg_glitch, cfg_lock;
  logic hib_cmd, btn_hit, btn_wake, wake_any;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    hwk_pin_detect #(
      .SYNC_DEPTH(SYNC_DEPTH),
      .FILT_DEPTH(FILT_DEPTH),
      .RST_VAL   (1'b0)
    ) u_det (
      .clk      (clk_ao),
      .rst_n    (rst_por_n),
      .din      (wake_pin_i[g]),
      .glitch_en(cfg_glitch),
      .edge_mode(cfg_trig[g]),
      .pol      (cfg_pol[g]),
      .hit      (pin_hit[g])
    );
  end

  hwk_pin_detect #(
    .SYNC_DEPTH(SYNC_DEPTH),
    .FILT_DEPTH(FILT_DEPTH),
    .RST_VAL   (1'b1)
  ) u_btn (
    .clk      (clk_ao),
    .rst_n    (rst_por_n),
    .din      (rstbtn_n_i),
    .glitch_en(cfg_glitch),
    .edge_mode(1'b1),
    .pol      (1'b0),
    .hit      (btn_hit)
  );

  assign btn_wake = btn_hit & cfg_btn_en;
  assign wake_any = (|pin_hit) | btn_wake | tmr_evt_i;

  hwk_regs u_regs (
    .clk      (clk_ao),
    .rst_n    (rst_por_n),
    .wr       (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .pin_hit  (pin_hit),
    .btn_wake (btn_wake),
    .tmr_hit  (tmr_evt_i),
    .trig     (cfg_trig),
    .pol      (cfg_pol),
    .pulse    (cfg_pulse),
    .od       (cfg_od),
    .btn_en   (cfg_btn_en),
    .gpo      (gpo_o),
    .glitch_en(cfg_glitch),
    .lock     (cfg_lock),
    .hib_cmd  (hib_cmd),
    .rdata    (reg_rdata_o)
  );

  hwk_pwr_out #(.PULSE_LEN(PULSE_LEN)) u_pwr (
    .clk    (clk_ao),
    .rst_n  (rst_por_n),
    .wake   (wake_any),
    .hib_cmd(hib_cmd),
    .pulse  (cfg_pulse),
    .od     (cfg_od),
    .pwr    (pwr_en_o),
    .oe     (pwr_en_oe_o),
    .cfg_err(cfg_err_o)
  );
endmodule

// File: rtl/hwk_wake_ctrl_chk.sv
`timescale 1ns/1ps
module hwk_wake_ctrl_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       pwr_en,
  input logic       pwr_oe,
  input logic       gpo,
  input logic       cfg_err,
  input logic       mode_pulse,
  input logic       mode_od,
  input logic       lock,
  input logic       btn_en
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (mode_pulse && pwr_en) begin
      if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
    end else hi_run <= '0;
  end

  // R5
  level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pulse && $past(!mode_pulse) && $fell(pwr_en)) |->
      $past(reg_wr && reg_addr == 2'd2 && reg_wdata[6]));

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pulse && pwr_en) |-> (hi_run < 16'(PULSE_LEN)));

  // R6
  pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pulse && $past(mode_pulse) && $rose(pwr_en)) |=> (pwr_en || !mode_pulse));

  // R7
  od_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_od && mode_pulse && pwr_oe) |-> !pwr_en);

  // R7
  cfg_err_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> pwr_oe);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> lock);

  // R9
  btn_en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> $stable(btn_en));

  // R12
  gpo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr && reg_addr == 2'd2) |-> $stable(gpo));
endmodule

bind hwk_wake_ctrl hwk_wake_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk_ao),
  .rst_n     (rst_por_n),
  .reg_wr    (reg_wr_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .pwr_en    (pwr_en_o),
  .pwr_oe    (pwr_en_oe_o),
  .gpo       (gpo_o),
  .cfg_err   (cfg_err_o),
  .mode_pulse(cfg_pulse),
  .mode_od   (cfg_od),
  .lock      (cfg_lock),
  .btn_en    (cfg_btn_en)
);

// File: tb/hwk_wake_ctrl_bench.sv
`timescale 1ns/1ps
module hwk_wake_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b0;
  logic       btn_n = 1'b1;
  logic       tmr = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pwr, oe, gpo, cerr;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  hwk_wake_ctrl u_hwk_wake_ctrl (
    .clk_ao(clk), .rst_por_n(rst_n), .wake_pin_i(pins), .rstbtn_n_i(btn_n),
    .tmr_evt_i(tmr), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pwr_en_o(pwr), .pwr_en_oe_o(oe), .gpo_o(gpo),
    .cfg_err_o(cerr)
  );

  // Behavioural reference model
  logic [3:0] m_trig, m_pol, m_pevt;
  logic m_pulse, m_od, m_ben, m_bevt, m_tevt, m_gpo, m_gen, m_lock, m_lvl;
  int   m_cnt;
  logic [4:0] m_d0, m_d1, m_d2, m_d3, m_fq, m_pv;

  always @(posedge clk or negedge rst_n) begin : model
    logic [4:0] filt, hit, ag;
    logic tm, pl, bw, wake, hib;
    if (!rst_n) begin
      m_trig = 4'h0; m_pol = 4'hF; m_pevt = 4'h0;
      m_pulse = 0; m_od = 0; m_ben = 0; m_bevt = 0; m_tevt = 0;
      m_gpo = 0; m_gen = 0; m_lock = 0; m_lvl = 1; m_cnt = 0;
      m_d0 = 5'b10000; m_d1 = 5'b10000; m_d2 = 5'b10000; m_d3 = 5'b10000;
      m_fq = 5'b10000; m_pv = 5'b10000;
    end else begin
      filt = m_gen ? m_fq : m_d1;
      for (int i = 0; i < 5; i++) begin
        tm = (i < 4) ? m_trig[i] : 1'b1;
        pl = (i < 4) ? m_pol[i] : 1'b0;
        if (tm) hit[i] = pl ? (filt[i] && !m_pv[i]) : (!filt[i] && m_pv[i]);
        else    hit[i] = (filt[i] == pl);
      end
      bw   = hit[4] && m_ben;
      wake = (|hit[3:0]) || bw || tmr;
      hib  = wr && addr == 2'd2 && wdata[6];
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (m_pulse && wake) m_cnt = 4;
      if (!m_pulse) begin
        if (wake) m_lvl = 1;
        else if (hib) m_lvl = 0;
      end
      m_pevt = (m_pevt & ~((wr && addr == 2'd0) ? wdata[3:0] : 4'h0)) | hit[3:0];
      m_bevt = (m_bevt && !(wr && addr == 2'd2 && wdata[3])) || bw;
      m_tevt = (m_tevt && !(wr && addr == 2'd2 && wdata[4])) || tmr;
      ag = ~(m_d1 ^ m_d2) & ~(m_d2 ^ m_d3);
      m_fq = (ag & m_d1) | (~ag & m_fq);
      m_pv = filt;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = m_d0; m_d0 = {btn_n, pins};
      if (wr) begin
        case (addr)
          2'd0: m_trig = wdata[7:4];
          2'd1: m_pol = {wdata[6], wdata[4], wdata[2], wdata[0]};
          2'd2: begin
            m_pulse = wdata[0]; m_od = wdata[1]; m_gpo = wdata[5];
            if (!m_lock) m_ben = wdata[2];
          end
          default: begin
            m_gen = wdata[0];
            if (!m_lock) m_lock = wdata[1];
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {m_trig, m_pevt};
      2'd1: return {1'b0, m_pol[3], 1'b0, m_pol[2], 1'b0, m_pol[1], 1'b0, m_pol[0]};
      2'd2: return {2'b00, m_gpo, m_tevt, m_bevt, m_ben, m_od, m_pulse};
      default: return {6'b0, m_lock, m_gen};
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic e_pwr;
    @(negedge clk);
    e_pwr = m_pulse ? (m_cnt != 0) : m_lvl;
    cmp(cur_req, "pwr_en", {7'b0, pwr}, {7'b0, e_pwr});
    cmp("R7", "pwr_oe", {7'b0, oe}, {7'b0, (m_od && m_pulse) ? !e_pwr : 1'b1});
    cmp("R7", "cfg_err", {7'b0, cerr}, {7'b0, m_od && !m_pulse});
    cmp("R12", "gpo", {7'b0, gpo}, {7'b0, m_gpo});
    cmp(cur_req, "rdata", rdata, exp_rd(addr));
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic reset_all();
    rst_n = 1'b0;
    ticks(2);
    rst_n = 1'b1;
    // R1 reset values of every register
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      tick();
    end
  endtask

  initial begin : watchdog
    #(64'd8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    cur_req = "R1";
    reset_all();

    // R5 hibernate in level mode, then R2 level wake on pin0
    cur_req = "R5";
    wreg(2'd2, 8'h40); ticks(3);
    cur_req = "R2";
    pins[0] = 1'b1; addr = 2'd0; ticks(5);
    // R5 collision: hibernate while pin0 level still active
    cur_req = "R5";
    wreg(2'd2, 8'h40); ticks(2);
    pins[0] = 1'b0; ticks(4);
    wreg(2'd2, 8'h40); ticks(2);
    // R10 timer strobe in same cycle as hibernate
    cur_req = "R10";
    wr = 1'b1; addr = 2'd2; wdata = 8'h40; tmr = 1'b1;
    tick();
    wr = 1'b0; tmr = 1'b0; ticks(2);
    // R11 clear with simultaneous new timer event, then plain clears
    cur_req = "R11";
    wr = 1'b1; addr = 2'd2; wdata = 8'h10; tmr = 1'b1;
    tick();
    wr = 1'b0; tmr = 1'b0; ticks(1);
    wreg(2'd2, 8'h10); ticks(1);
    wreg(2'd0, 8'h0F); ticks(1);

    // R3 pin1 edge-triggered, falling
    cur_req = "R3";
    wreg(2'd1, 8'h51);
    wreg(2'd0, 8'h20);
    wreg(2'd2, 8'h40); ticks(2);
    pins[1] = 1'b1; ticks(6);
    pins[1] = 1'b0; ticks(6);

    // R4 glitch filter on pin2
    cur_req = "R4";
    wreg(2'd3, 8'h01);
    wreg(2'd2, 8'h40); ticks(2);
    pins[2] = 1'b1; tick(); pins[2] = 1'b0; ticks(6);
    pins[2] = 1'b1; ticks(2); pins[2] = 1'b0; ticks(6);
    pins[2] = 1'b1; ticks(3); pins[2] = 1'b0; ticks(8);
    wreg(2'd3, 8'h00); ticks(2);

    // R6 pulse mode
    cur_req = "R6";
    wreg(2'd2, 8'h01); ticks(2);
    tmr = 1'b1; tick(); tmr = 1'b0; tick();
    tmr = 1'b1; tick(); tmr = 1'b0; ticks(6);
    wreg(2'd2, 8'h41); ticks(3);
    pins[3] = 1'b1; ticks(12); pins[3] = 1'b0; ticks(8);

    // R7 open drain in pulse mode, then illegal in level mode
    cur_req = "R7";
    wreg(2'd2, 8'h03); ticks(2);
    tmr = 1'b1; tick(); tmr = 1'b0; ticks(6);
    wreg(2'd2, 8'h02); ticks(3);

    // R8 reset button wake
    cur_req = "R8";
    wreg(2'd2, 8'h04);
    wreg(2'd2, 8'h44); ticks(2);
    btn_n = 1'b0; addr = 2'd2; ticks(6);
    btn_n = 1'b1; ticks(6);

    // R9 lock
    cur_req = "R9";
    wreg(2'd3, 8'h03);
    wreg(2'd2, 8'h00);
    wreg(2'd3, 8'h00);
    addr = 2'd2; ticks(2);
    addr = 2'd3; ticks(2);

    // R12 general output retained through hibernate
    cur_req = "R12";
    wreg(2'd2, 8'h24); ticks(2);
    wreg(2'd2, 8'h64); ticks(3);
    tmr = 1'b1; tick(); tmr = 1'b0; ticks(3);

    // R1 / R9 power-on reset clears lock
    cur_req = "R1";
    reset_all();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule